// File: doc/BRIEF.md
# Register File with Deferred Load Faults

This block is a small general-purpose register file in which every register has one extra tag bit that marks its contents as poisoned. A load unit that runs a load ahead of its controlling branch writes the result through the write port with a speculative flag. If that load faulted, the fault is not reported. The destination's tag is set, and the fault waits there until something actually needs the value.

A poisoned value is reported at one of two points. The first is when a committed, non-speculative consumer reads the register through one of the two read ports. The second is when an explicit check operation names the register. A load that is not speculative and faults reports at once, and its destination is left untouched. Every report is a one-cycle pulse that carries a cause code and the register index. A consumer can therefore be stopped precisely at the instruction that needs the bad value.

Top module: `poison_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register's data to zero, clears every poison tag and drops `exc_valid`.
- R2: A write with `wr_fault` low stores `wr_data` and clears the register's poison tag, whatever `wr_spec` is. The value is visible on both read ports from the next cycle on.
- R3: A write with both `wr_spec` and `wr_fault` high sets the register's poison tag and raises no exception. The register's data is then unspecified.
- R4: A write with `wr_fault` high and `wr_spec` low changes neither data nor tag. The next cycle it pulses `exc_valid` with `exc_cause` = 1 (load fault) and `exc_idx` = `wr_idx`.
- R5: Register 0 always reads zero with its poison flag low, and writes to it have no effect.
- R6: When a write hits the register that a read port or the check port names in the same cycle, that port shows the new data and the new poison state.
- R7: A read port whose use flag is high and whose register is poisoned causes, in the next cycle, an `exc_valid` pulse with `exc_cause` = 2 (deferred use) and `exc_idx` set to that register.
- R8: A read port whose use flag is low returns data and poison flag but never raises an exception.
- R9: `chk_pending` shows the poison state of `chk_idx` in the same cycle. With `chk_en` high on a poisoned register, the next cycle pulses `exc_valid` with `exc_cause` = 3 (check). On a clean register the check does nothing.
- R10: When several causes arise in one cycle, one is reported, in this order of precedence: a non-speculative load fault, then read port A, then read port B, then the check port.
- R11: `exc_valid` is high only in the cycle after a cause is present, and `exc_cause` is 0 whenever `exc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request from the load unit |
| wr_idx | input | IW | Destination register |
| wr_data | input | DW | Load data |
| wr_spec | input | 1 | Load was issued speculatively |
| wr_fault | input | 1 | Load encountered an exception |
| rd_a_idx | input | IW | Read port A register |
| rd_a_use | input | 1 | Port A read is a committed consumer |
| rd_a_data | output | DW | Port A data |
| rd_a_poison | output | 1 | Port A register is poisoned |
| rd_b_idx | input | IW | Read port B register |
| rd_b_use | input | 1 | Port B read is a committed consumer |
| rd_b_data | output | DW | Port B data |
| rd_b_poison | output | 1 | Port B register is poisoned |
| chk_en | input | 1 | Speculation check request |
| chk_idx | input | IW | Register to check |
| chk_pending | output | 1 | Checked register holds a deferred fault |
| exc_valid | output | 1 | Exception pulse |
| exc_idx | output | IW | Register index of the exception |
| exc_cause | output | 2 | 1 load fault, 2 deferred use, 3 check |

## Verification
Every register is written with a distinct clean pattern and then read back on both ports. This shows that index decoding is correct and that register 0 stays zero. Odd registers are then poisoned and swept with non-using reads, with checks and with using reads on each port in turn. This separates tag storage from exception raising and keeps the three cause codes apart. Writes to the same register as a read in the same cycle, both clean and faulting, show whether the bypass carries data and tag. A cycle in which all four causes are present, followed by cycles with the winners removed one at a time, fixes the precedence order.

// File: rtl/prf_pkg.sv
package prf_pkg;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_LOAD  = 2'd1,
        EXC_USE   = 2'd2,
        EXC_CHECK = 2'd3
    } exc_cause_e;

    // Meaning of one write-port request
    typedef struct packed {
        logic commit;   // register is updated (data and/or tag)
        logic poison;   // new tag value when committed
        logic raise;    // immediate load fault to report
    } wr_decode_t;

    function automatic wr_decode_t decode_write(input logic en,
                                                input logic spec,
                                                input logic fault);
        wr_decode_t d;
        d.raise  = en && fault && !spec;
        d.commit = en && !d.raise;
        d.poison = fault;
        return d;
    endfunction

endpackage

// File: rtl/prf_store.sv
module prf_store #(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit_i,
    input  logic                       poison_i,
    input  logic [IW-1:0]              idx_i,
    input  logic [DW-1:0]              data_i,
    output logic [NREGS-1:0][DW-1:0]   regs_o,
    output logic [NREGS-1:0]           pois_o
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs_o[g] = '0;
            assign pois_o[g] = 1'b0;
        end else begin : g_live
            logic hit;
            assign hit = commit_i && (idx_i == IW'(g));
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_o[g] <= '0;
                    pois_o[g] <= 1'b0;
                end else if (hit) begin
                    pois_o[g] <= poison_i;
                    if (!poison_i) regs_o[g] <= data_i;
                end
            end
        end
    end
endmodule

// File: rtl/prf_poison_lookup.sv
module prf_poison_lookup #(
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic [IW-1:0]     idx_i,
    input  logic [NREGS-1:0]  pois_i,
    input  logic              commit_i,
    input  logic              poison_i,
    input  logic [IW-1:0]     wr_idx_i,
    output logic              pois_o
);
    always_comb begin
        if (idx_i == '0)
            pois_o = 1'b0;
        else if (commit_i && wr_idx_i == idx_i)
            pois_o = poison_i;
        else
            pois_o = pois_i[idx_i];
    end
endmodule

// File: rtl/prf_read_port.sv
module prf_read_port #(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic [IW-1:0]             idx_i,
    input  logic [NREGS-1:0][DW-1:0]  regs_i,
    input  logic [NREGS-1:0]          pois_i,
    input  logic                      commit_i,
    input  logic                      poison_i,
    input  logic [IW-1:0]             wr_idx_i,
    input  logic [DW-1:0]             wr_data_i,
    output logic [DW-1:0]             data_o,
    output logic                      pois_o
);
    prf_poison_lookup #(.NREGS(NREGS)) u_lookup (
        .idx_i(idx_i), .pois_i(pois_i), .commit_i(commit_i),
        .poison_i(poison_i), .wr_idx_i(wr_idx_i), .pois_o(pois_o)
    );

    always_comb begin
        if (idx_i == '0)
            data_o = '0;
        else if (commit_i && !poison_i && wr_idx_i == idx_i)
            data_o = wr_data_i;
        else
            data_o = regs_i[idx_i];
    end
endmodule

// File: rtl/prf_fault_arb.sv
module prf_fault_arb
    import prf_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_raise_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic          use_a_i,
    input  logic [IW-1:0] idx_a_i,
    input  logic          pois_a_i,
    input  logic          use_b_i,
    input  logic [IW-1:0] idx_b_i,
    input  logic          pois_b_i,
    input  logic          chk_en_i,
    input  logic [IW-1:0] chk_idx_i,
    input  logic          chk_pois_i,
    output logic          exc_valid_o,
    output logic [IW-1:0] exc_idx_o,
    output exc_cause_e    exc_cause_o
);
    logic          nxt_valid;
    logic [IW-1:0] nxt_idx;
    exc_cause_e    nxt_cause;

    always_comb begin
        nxt_valid = 1'b1;
        nxt_idx   = '0;
        nxt_cause = EXC_NONE;
        if (load_raise_i) begin
            nxt_idx = wr_idx_i;    nxt_cause = EXC_LOAD;
        end else if (use_a_i && pois_a_i) begin
            nxt_idx = idx_a_i;     nxt_cause = EXC_USE;
        end else if (use_b_i && pois_b_i) begin
            nxt_idx = idx_b_i;     nxt_cause = EXC_USE;
        end else if (chk_en_i && chk_pois_i) begin
            nxt_idx = chk_idx_i;   nxt_cause = EXC_CHECK;
        end else begin
            nxt_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid_o <= 1'b0;
            exc_idx_o   <= '0;
            exc_cause_o <= EXC_NONE;
        end else begin
            exc_valid_o <= nxt_valid;
            exc_idx_o   <= nxt_idx;
            exc_cause_o <= nxt_cause;
        end
    end

    // R4
    load_fault_chk: assert property (@(posedge clk) disable iff (rst)
        load_raise_i |=> (exc_valid_o && exc_cause_o == EXC_LOAD
                          && exc_idx_o == $past(wr_idx_i)));

    // R10
    a_over_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_raise_i && use_a_i && pois_a_i)
            |=> (exc_cause_o == EXC_USE && exc_idx_o == $past(idx_a_i)));

    // R11
    cause_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_valid_o == (exc_cause_o != EXC_NONE)));

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_raise_i && !(use_a_i && pois_a_i) && !(use_b_i && pois_b_i)
         && !(chk_en_i && chk_pois_i)) |=> !exc_valid_o);
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
    import prf_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_spec,
    input  logic          wr_fault,
    input  logic [IW-1:0] rd_a_idx,
    input  logic          rd_a_use,
    output logic [DW-1:0] rd_a_data,
    output logic          rd_a_poison,
    input  logic [IW-1:0] rd_b_idx,
    input  logic          rd_b_use,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_poison,
    input  logic          chk_en,
    input  logic [IW-1:0] chk_idx,
    output logic          chk_pending,
    output logic          exc_valid,
    output logic [IW-1:0] exc_idx,
    output logic [1:0]    exc_cause
);
    wr_decode_t                dec;
    logic [NREGS-1:0][DW-1:0]  regs;
    logic [NREGS-1:0]          pois;
    logic [1:0][IW-1:0]        port_idx;
    logic [1:0][DW-1:0]        port_data;
    logic [1:0]                port_pois;
    exc_cause_e                cause;

    assign dec         = decode_write(wr_en, wr_spec, wr_fault);
    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;

    prf_store #(.NREGS(NREGS), .DW(DW)) u_store (
        .clk(clk), .rst(rst), .commit_i(dec.commit), .poison_i(dec.poison),
        .idx_i(wr_idx), .data_i(wr_data), .regs_o(regs), .pois_o(pois)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        prf_read_port #(.NREGS(NREGS), .DW(DW)) u_port (
            .idx_i(port_idx[p]), .regs_i(regs), .pois_i(pois),
            .commit_i(dec.commit), .poison_i(dec.poison),
            .wr_idx_i(wr_idx), .wr_data_i(wr_data),
            .data_o(port_data[p]), .pois_o(port_pois[p])
        );
    end

    assign rd_a_data   = port_data[0];
    assign rd_a_poison = port_pois[0];
    assign rd_b_data   = port_data[1];
    assign rd_b_poison = port_pois[1];

    prf_poison_lookup #(.NREGS(NREGS)) u_check (
        .idx_i(chk_idx), .pois_i(pois), .commit_i(dec.commit),
        .poison_i(dec.poison), .wr_idx_i(wr_idx), .pois_o(chk_pending)
    );

    prf_fault_arb #(.NREGS(NREGS)) u_arb (
        .clk(clk), .rst(rst), .load_raise_i(dec.raise), .wr_idx_i(wr_idx),
        .use_a_i(rd_a_use), .idx_a_i(rd_a_idx), .pois_a_i(rd_a_poison),
        .use_b_i(rd_b_use), .idx_b_i(rd_b_idx), .pois_b_i(rd_b_poison),
        .chk_en_i(chk_en), .chk_idx_i(chk_idx), .chk_pois_i(chk_pending),
        .exc_valid_o(exc_valid), .exc_idx_o(exc_idx), .exc_cause_o(cause)
    );
    assign exc_cause = cause;

    // R5
    r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0 && !rd_a_poison));

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_fault && wr_idx == rd_b_idx && wr_idx != '0)
            |-> (rd_b_data == wr_data && !rd_b_poison));

    // R3
    spec_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_spec && wr_fault && wr_idx != '0) |=> pois[$past(wr_idx)]);
endmodule

// File: tb/poison_regfile_tb_top.sv
module poison_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int DW = 16;
    localparam int IW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en, wr_spec, wr_fault, rd_a_use, rd_b_use, chk_en;
    logic [IW-1:0] wr_idx, rd_a_idx, rd_b_idx, chk_idx, exc_idx;
    logic [DW-1:0] wr_data, rd_a_data, rd_b_data;
    logic rd_a_poison, rd_b_poison, chk_pending, exc_valid;
    logic [1:0] exc_cause;

    int checks = 0, errors = 0;
    logic [DW-1:0] md [NR];
    logic          mp [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    poison_regfile #(.NREGS(NR), .DW(DW)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic raise_now();
        return wr_en && wr_fault && !wr_spec;
    endfunction

    function automatic logic eff_p(input logic [IW-1:0] i);
        if (i == 0) return 1'b0;
        if (wr_en && wr_idx == i && !raise_now()) return wr_fault;
        return mp[i];
    endfunction

    function automatic logic [DW-1:0] eff_d(input logic [IW-1:0] i);
        if (i == 0) return '0;
        if (wr_en && wr_idx == i && !wr_fault) return wr_data;
        return md[i];
    endfunction

    task automatic idle();
        wr_en = 0; wr_spec = 0; wr_fault = 0; wr_idx = 0; wr_data = 0;
        rd_a_idx = 0; rd_a_use = 0; rd_b_idx = 0; rd_b_use = 0;
        chk_en = 0; chk_idx = 0;
    endtask

    // Inputs are set; check combinational outputs, clock, then check the pulse
    task automatic cyc(input string req);
        logic ev; logic [IW-1:0] ei; logic [1:0] ec;
        #1;
        if (!eff_p(rd_a_idx)) chk(req, rd_a_data, eff_d(rd_a_idx));
        chk(req, rd_a_poison, eff_p(rd_a_idx));
        if (!eff_p(rd_b_idx)) chk(req, rd_b_data, eff_d(rd_b_idx));
        chk(req, rd_b_poison, eff_p(rd_b_idx));
        chk(req, chk_pending, eff_p(chk_idx));
        ev = 1; ei = 0; ec = 0;
        if (raise_now()) begin ei = wr_idx; ec = 1; end
        else if (rd_a_use && eff_p(rd_a_idx)) begin ei = rd_a_idx; ec = 2; end
        else if (rd_b_use && eff_p(rd_b_idx)) begin ei = rd_b_idx; ec = 2; end
        else if (chk_en && eff_p(chk_idx)) begin ei = chk_idx; ec = 3; end
        else ev = 0;
        @(posedge clk);
        if (wr_en && !raise_now() && wr_idx != 0) begin
            mp[wr_idx] = wr_fault;
            if (!wr_fault) md[wr_idx] = wr_data;
        end
        @(negedge clk); #1;
        chk({req, "/R11"}, exc_valid, ev);
        chk({req, "/R11"}, exc_cause, ec);
        if (ev) chk(req, exc_idx, ei);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin md[i] = '0; mp[i] = 1'b0; end
        idle();
        repeat (3) @(negedge clk);
        rst = 0; #1;
        // R1: reset state
        chk("R1", exc_valid, 0);
        for (int i = 0; i < NR; i++) begin rd_a_idx = IW'(i); rd_b_idx = IW'(NR-1-i); cyc("R1"); end
        // R2 + R6: clean writes with same-cycle read on port A
        for (int i = 0; i < NR; i++) begin
            wr_en = 1; wr_idx = IW'(i); wr_data = DW'(i * 16'h1111 ^ 16'h00A5);
            wr_spec = i[0]; rd_a_idx = IW'(i); cyc(i == 0 ? "R5" : "R6");
        end
        for (int i = 0; i < NR; i++) begin rd_a_idx = IW'(i); rd_b_idx = IW'(i); cyc("R2"); end
        // R3: poison odd registers with faulting speculative loads
        for (int i = 1; i < NR; i += 2) begin
            wr_en = 1; wr_spec = 1; wr_fault = 1; wr_idx = IW'(i); wr_data = 16'hDEAD; cyc("R3");
        end
        // R5: faulting speculative write to register 0 is ignored
        wr_en = 1; wr_spec = 1; wr_fault = 1; wr_idx = 0; cyc("R5");
        rd_a_idx = 0; rd_a_use = 1; cyc("R5");
        // R8: reads without use flag
        for (int i = 0; i < NR; i++) begin rd_a_idx = IW'(i); rd_b_idx = IW'(i); cyc("R8"); end
        // R9: check sweep
        for (int i = 0; i < NR; i++) begin chk_en = 1; chk_idx = IW'(i); cyc("R9"); end
        // R7: use sweep on each port
        for (int i = 0; i < NR; i++) begin rd_a_idx = IW'(i); rd_a_use = 1; cyc("R7"); end
        for (int i = 0; i < NR; i++) begin rd_b_idx = IW'(i); rd_b_use = 1; cyc("R7"); end
        // R4: non-speculative fault leaves register 2 intact
        wr_en = 1; wr_fault = 1; wr_idx = 2; wr_data = 16'hBEEF; cyc("R4");
        rd_a_idx = 2; cyc("R4");
        // R10: precedence, dropping the winner each time
        for (int k = 0; k < 4; k++) begin
            if (k < 1) begin wr_en = 1; wr_fault = 1; wr_idx = 2; end
            if (k < 2) begin rd_a_idx = 3; rd_a_use = 1; end
            if (k < 3) begin rd_b_idx = 5; rd_b_use = 1; end
            chk_en = 1; chk_idx = 7; cyc("R10");
        end
        // R2: clean write clears poison of 3
        wr_en = 1; wr_idx = 3; wr_data = 16'h1234; cyc("R2");
        rd_a_idx = 3; rd_a_use = 1; cyc("R2");
        // R6: poison bypass to a using read and to the check port
        wr_en = 1; wr_spec = 1; wr_fault = 1; wr_idx = 4;
        rd_a_idx = 4; rd_a_use = 1; chk_idx = 4; cyc("R6");
        wr_en = 1; wr_idx = 5; wr_data = 16'h0F0F; rd_b_idx = 5; rd_b_use = 1; chk_en = 1; chk_idx = 5; cyc("R6");
        // R11: idle cycles, no pulse
        cyc("R11"); cyc("R11");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule